// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the serial clock of a standard-mode or fast-mode I2C master from a faster functional clock. A programmable prescaler first divides the functional clock into an internal timing tick. The tick then paces two phase timers: one for the time SCL is held low and one for the time it is released high. Each phase lasts its programmed 8-bit value plus a fixed number of extra ticks.

The SCL output is an open-drain style pull-low request. While it is asserted the pad drives the line low, and while it is deasserted the line floats high. Two single-cycle strobes mark the middle of the low phase and the middle of the high phase. A bit engine uses the first to change SDA and the second to sample SDA. Prescaler and phase settings are captured into shadow copies only at a period boundary, or while the generator is off. A running period therefore never has a phase cut short or stretched.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `scl_pull_low`, `mid_low_stb` and `mid_high_stb` are all 0.
- R2: While `en` is low the generator is off: on the clock edge after `en` is sampled low, `scl_pull_low` is 0 and no strobe fires, whatever the configuration inputs hold.
- R3: Every low phase lasts exactly (L + 7) x (P + 1) functional-clock cycles. L is `scl_lo_cfg[7:0]` and P is `presc_cfg[7:0]`.
- R4: Every high phase lasts exactly (H + 5) x (P + 1) functional-clock cycles, where H is `scl_hi_cfg[7:0]`.
- R5: Bits [15:8] of `scl_lo_cfg` and `scl_hi_cfg` have no effect on the waveform.
- R6: With P = 1, the pairs L/H = 111/117, 23/25 and 5/7 give periods of 480, 120 and 48 functional-clock cycles. These are 100 kHz, 400 kHz and 1 MHz from a 48 MHz clock.
- R7: A change of P, L or H made during a period does not alter that period. It takes effect from the next low phase.
- R8: `mid_low_stb` pulses exactly once per low phase, at cycle offset floor((L+7)/2) x (P+1) - 1 counted from the first low cycle. `mid_high_stb` pulses exactly once per high phase, at offset floor((H+5)/2) x (P+1) - 1. The two strobes never fire together.
- R9: The first phase after `en` rises is a low phase, and `scl_pull_low` is 1 on the clock edge where `en` is first sampled high.
- R10: Dropping `en` mid-period releases SCL at the next edge. Re-enabling starts a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable |
| presc_cfg | input | 8 | Prescaler value P; the tick is clk / (P+1) |
| scl_lo_cfg | input | 16 | Low-phase setting; bits [7:0] used |
| scl_hi_cfg | input | 16 | High-phase setting; bits [7:0] used |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release SCL |
| mid_low_stb | output | 1 | One-cycle pulse at the middle of a low phase |
| mid_high_stb | output | 1 | One-cycle pulse at the middle of a high phase |

## Verification
The three standard settings, with the prescaler dividing by two, tell apart the low and high extra-tick offsets. The 236/244-cycle case would expose swapped offsets, and the 24/24-cycle case would expose a dropped prescaler. A divide-by-one case with a small odd phase length checks the floor in the strobe offset. A divide-by-three case with garbage in the upper register bytes shows that only the low byte matters. Rewriting the settings during a low phase shows that the shadow copy keeps the current period intact and switches exactly at the next low phase. A mid-period disable and re-enable checks the release and the full-length restart.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   localparam int unsigned SCL_FIELD_W   = 8;
   localparam int unsigned SCL_REG_W     = 16;
   localparam int unsigned SCL_LOW_ADD   = 7;
   localparam int unsigned SCL_HIGH_ADD  = 5;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } scl_phase_e;

endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
   parameter int unsigned PSC_W   = 8,
   parameter int unsigned FIELD_W = 8,
   parameter int unsigned REG_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [PSC_W-1:0]   psc_in,
   input  logic [REG_W-1:0]   lo_in,
   input  logic [REG_W-1:0]   hi_in,
   output logic [PSC_W-1:0]   psc_q,
   output logic [FIELD_W-1:0] lo_q,
   output logic [FIELD_W-1:0] hi_q
);

   generate
      if (FIELD_W > REG_W) begin : g_bad_width
         $error("scl_cfg_shadow: FIELD_W must not exceed REG_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q <= '0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else if (load) begin
         psc_q <= psc_in;
         lo_q  <= lo_in[FIELD_W-1:0];
         hi_q  <= hi_in[FIELD_W-1:0];
      end
   end

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(psc_q) && $stable(lo_q) && $stable(hi_q))); // R7

endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
   parameter int unsigned PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] div_val,
   output logic             tick
);

   logic [PSC_W-1:0] pcnt;

   generate
      if (PSC_W < 1) begin : g_bad_psc
         $error("scl_tick_div: PSC_W must be at least 1");
      end
   endgenerate

   assign tick = run && (pcnt == div_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (!run || tick) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end

   AST_PCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (pcnt <= div_val)); // R3
   AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pcnt == '0)); // R2

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
   import scl_gen_pkg::*;
#(
   parameter int unsigned FIELD_W     = 8,
   parameter int unsigned LOW_EXTRA   = 7,
   parameter int unsigned HIGH_EXTRA  = 5,
   parameter bit          MID_STROBES = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic [FIELD_W-1:0] lo_val,
   input  logic [FIELD_W-1:0] hi_val,
   output scl_phase_e         phase,
   output logic               period_end,
   output logic               mid_lo,
   output logic               mid_hi
);

   localparam int unsigned LEN_W = FIELD_W + 1;

   logic [LEN_W-1:0] tcnt;
   logic [LEN_W-1:0] cur_len;
   logic [LEN_W-1:0] half_len;
   logic             last_tick;

   generate
      if (LOW_EXTRA < 2 || HIGH_EXTRA < 2) begin : g_bad_extra
         $error("scl_phase_timer: extra ticks must be at least 2");
      end
   endgenerate

   always_comb begin
      if (phase == PH_LOW) cur_len = {1'b0, lo_val} + LEN_W'(LOW_EXTRA);
      else                 cur_len = {1'b0, hi_val} + LEN_W'(HIGH_EXTRA);
      half_len  = cur_len >> 1;
      last_tick = (tcnt == cur_len - 1'b1);
   end

   assign period_end = tick && last_tick && (phase == PH_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt  <= '0;
         phase <= PH_LOW;
      end else if (!run) begin
         tcnt  <= '0;
         phase <= PH_LOW;
      end else if (tick) begin
         if (last_tick) begin
            tcnt  <= '0;
            phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   generate
      if (MID_STROBES) begin : g_strobes
         logic at_mid;
         assign at_mid = tick && (tcnt == half_len - 1'b1);
         assign mid_lo = at_mid && (phase == PH_LOW);
         assign mid_hi = at_mid && (phase == PH_HIGH);
      end else begin : g_no_strobes
         assign mid_lo = 1'b0;
         assign mid_hi = 1'b0;
      end
   endgenerate

   AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(phase)); // R4
   AST_TCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tcnt < cur_len); // R3

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
   import scl_gen_pkg::*;
#(
   parameter int unsigned PSC_W       = 8,
   parameter int unsigned FIELD_W     = SCL_FIELD_W,
   parameter int unsigned REG_W       = SCL_REG_W,
   parameter int unsigned LOW_EXTRA   = SCL_LOW_ADD,
   parameter int unsigned HIGH_EXTRA  = SCL_HIGH_ADD,
   parameter bit          MID_STROBES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PSC_W-1:0] presc_cfg,
   input  logic [REG_W-1:0] scl_lo_cfg,
   input  logic [REG_W-1:0] scl_hi_cfg,
   output logic             scl_pull_low,
   output logic             mid_low_stb,
   output logic             mid_high_stb
);

   logic               run;
   logic               tick;
   logic               period_end;
   logic               shadow_load;
   logic [PSC_W-1:0]   psc_sh;
   logic [FIELD_W-1:0] lo_sh;
   logic [FIELD_W-1:0] hi_sh;
   scl_phase_e         phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= 1'b0;
      else        run <= en;
   end

   assign shadow_load = !run || period_end;

   scl_cfg_shadow #(
      .PSC_W  (PSC_W),
      .FIELD_W(FIELD_W),
      .REG_W  (REG_W)
   ) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (shadow_load),
      .psc_in(presc_cfg),
      .lo_in (scl_lo_cfg),
      .hi_in (scl_hi_cfg),
      .psc_q (psc_sh),
      .lo_q  (lo_sh),
      .hi_q  (hi_sh)
   );

   scl_tick_div #(
      .PSC_W(PSC_W)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .div_val(psc_sh),
      .tick   (tick)
   );

   scl_phase_timer #(
      .FIELD_W    (FIELD_W),
      .LOW_EXTRA  (LOW_EXTRA),
      .HIGH_EXTRA (HIGH_EXTRA),
      .MID_STROBES(MID_STROBES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (tick),
      .lo_val    (lo_sh),
      .hi_val    (hi_sh),
      .phase     (phase),
      .period_end(period_end),
      .mid_lo    (mid_low_stb),
      .mid_hi    (mid_high_stb)
   );

   assign scl_pull_low = run && (phase == PH_LOW);

   AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!scl_pull_low && !mid_low_stb && !mid_high_stb)); // R2
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !run) |=> scl_pull_low); // R9
   AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mid_low_stb && mid_high_stb)); // R8
   AST_LOW_STB_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      mid_low_stb |-> scl_pull_low); // R8
   AST_HIGH_STB_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      mid_high_stb |-> (run && !scl_pull_low)); // R8

endmodule

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [7:0]  presc_cfg = '0;
   logic [15:0] scl_lo_cfg = '0;
   logic [15:0] scl_hi_cfg = '0;
   logic        scl_pull_low;
   logic        mid_low_stb;
   logic        mid_high_stb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   scl_rate_gen u_scl_rate_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .presc_cfg   (presc_cfg),
      .scl_lo_cfg  (scl_lo_cfg),
      .scl_hi_cfg  (scl_hi_cfg),
      .scl_pull_low(scl_pull_low),
      .mid_low_stb (mid_low_stb),
      .mid_high_stb(mid_high_stb)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int lo_w(int p, int l); return (l + 7) * (p + 1); endfunction
   function automatic int hi_w(int p, int h); return (h + 5) * (p + 1); endfunction
   function automatic int lo_s(int p, int l); return ((l + 7) / 2) * (p + 1) - 1; endfunction
   function automatic int hi_s(int p, int h); return ((h + 5) / 2) * (p + 1) - 1; endfunction

   // Called on a negedge in the first low cycle; returns on the first low cycle
   // of the next period.
   task automatic run_period(input int p, input int l, input int h, input string req);
      int n;
      int nstb;
      int pos;
      bit wrong;
      n = 0; nstb = 0; pos = -1; wrong = 0;
      while (scl_pull_low && n < 5000) begin
         if (mid_low_stb) begin nstb++; pos = n; end
         if (mid_high_stb) wrong = 1;
         @(negedge clk); n++;
      end
      chk(n == lo_w(p, l), req, "low width (R3)", n, lo_w(p, l));
      chk(nstb == 1 && pos == lo_s(p, l) && !wrong, req, "low mid strobe (R8)", pos, lo_s(p, l));
      n = 0; nstb = 0; pos = -1; wrong = 0;
      while (!scl_pull_low && n < 5000) begin
         if (mid_high_stb) begin nstb++; pos = n; end
         if (mid_low_stb) wrong = 1;
         @(negedge clk); n++;
      end
      chk(n == hi_w(p, h), req, "high width (R4)", n, hi_w(p, h));
      chk(nstb == 1 && pos == hi_s(p, h) && !wrong, req, "high mid strobe (R8)", pos, hi_s(p, h));
   endtask

   task automatic start_gen(input int p, input int lo, input int hi);
      @(negedge clk);
      en = 1'b0;
      presc_cfg = 8'(p); scl_lo_cfg = 16'(lo); scl_hi_cfg = 16'(hi);
      repeat (3) @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      chk(scl_pull_low == 1'b1, "R9", "pull low at start", int'(scl_pull_low), 1);
   endtask

   task automatic t_reset;
      chk(!scl_pull_low && !mid_low_stb && !mid_high_stb, "R1", "outputs in reset",
          int'({scl_pull_low, mid_low_stb, mid_high_stb}), 0);
   endtask

   task automatic t_table;
      start_gen(1, 111, 117);
      run_period(1, 111, 117, "R6 100k");
      run_period(1, 111, 117, "R6 100k");
      start_gen(1, 23, 25);
      run_period(1, 23, 25, "R6 400k");
      start_gen(1, 5, 7);
      run_period(1, 5, 7, "R6 1M");
   endtask

   task automatic t_upper_bits;
      start_gen(2, 16'hA504, 16'h5A03);
      run_period(2, 4, 3, "R5");
      run_period(2, 4, 3, "R5");
   endtask

   task automatic t_midperiod_change;
      start_gen(0, 3, 2);
      presc_cfg = 8'd0; scl_lo_cfg = 16'd1; scl_hi_cfg = 16'd10;
      run_period(0, 3, 2, "R7 current");
      run_period(0, 1, 10, "R7 next");
   endtask

   task automatic t_disable;
      bit seen;
      start_gen(0, 3, 2);
      repeat (4) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(scl_pull_low == 1'b0, "R10", "release after disable", int'(scl_pull_low), 0);
      seen = 0;
      scl_lo_cfg = 16'd0; scl_hi_cfg = 16'd0;
      for (int i = 0; i < 20; i++) begin
         if (scl_pull_low || mid_low_stb || mid_high_stb) seen = 1;
         @(negedge clk);
      end
      chk(!seen, "R2", "idle while disabled", int'(seen), 0);
      scl_lo_cfg = 16'd3; scl_hi_cfg = 16'd2;
      en = 1'b1;
      @(negedge clk);
      chk(scl_pull_low == 1'b1, "R9", "restart low", int'(scl_pull_low), 1);
      run_period(0, 3, 2, "R10 restart");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_table();
      t_upper_bits();
      t_midperiod_change();
      t_disable();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule